// File: doc/BRIEF.md
# Phase-Stepped I2C Bit Engine

This block turns byte-level commands into I2C line activity. A sequencer hands it one command at a time: start condition, repeated start, stop condition, write a byte, or read a byte. The engine drives both lines through pull-down enables. A write reports whether the receiver acknowledged. A read returns the byte and finishes with an ACK or a NACK, whichever the command asked for. Clock stretching and arbitration between several masters are not handled.

Each SCL bit slot has four phases, numbered 0 to 3:
- Phase 0: SCL is held low and SDA takes its new value.
- Phase 1: SCL is released.
- Phase 2: SCL stays released, and SDA is sampled at the end of this phase.
- Phase 3: SCL is pulled low again.

Phase n lasts (step_n + 1) prescaler ticks, and one tick occurs every (clkdiv + 1) clocks. This lets software shape asymmetric high and low times, for example to allow for slow rise times on a loaded bus.

A mode input selects one of three behaviours:
- Off: the engine's state machine is held in reset and both lines are released. Mode code 3 is treated the same way.
- Bit-bang: two register bits drive the lines directly, and the SDA input is captured on every clock.
- Sequenced: the command path described above.

Top module: `i2c_phase_engine`

## Requirements
- R1: After reset in sequenced mode (mode 2), both drive enables are 0 (lines released), busy_o is 0, done_o is 0 and cmd_ready_o is 1.
- R2: Within a bit slot, phase n lasts (step_n+1)*(clkdiv+1) clocks, where step_n is steps_i[8n+7:8n]. SCL is released only for phases 1 and 2, so a data bit's SCL high time is (step1+step2+2)*(clkdiv+1) clocks. The interval between consecutive SCL rises within a byte is the sum of all four phase lengths.
- R3: A start command (op 1) pulls SDA low while SCL is released, then pulls SCL low. It ends with both enables at 1.
- R4: A repeated start (op 5) first releases SDA while SCL is low, then releases SCL, then pulls SDA low while SCL is released, then pulls SCL low. No stop condition appears on the bus.
- R5: A stop (op 2) pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is released. It ends with both enables at 0.
- R6: A write (op 3) sends cmd_data_i MSB first, changing SDA only while SCL is low. On the ninth clock it releases SDA and reports the sampled level on rsp_nack_o (1 = NACK). rsp_data_o returns the eight sampled bus bits.
- R7: A read (op 4) releases SDA for eight clocks and assembles the levels sampled at the end of phase 2, MSB first, into rsp_data_o. On the ninth clock it pulls SDA low when cmd_nack_i was 0 and releases it when cmd_nack_i was 1.
- R8: A command is accepted when cmd_valid_i and cmd_ready_o are both 1. From the next cycle busy_o is 1 and cmd_ready_o is 0 until the command ends. The end is marked by done_o being high for exactly one cycle, after which cmd_ready_o is 1 again.
- R9: In bit-bang mode (mode 1), one clock after bb_lines_i changes, scl_oe_o equals the inverse of bb_lines_i[1] and sda_oe_o equals the inverse of bb_lines_i[0].
- R10: In bit-bang mode, bb_sda_o holds the value sda_i had on the previous clock.
- R11: In mode 0 or mode 3, one clock later both enables are 0, busy_o is 0 and cmd_ready_o is 0, even when a byte was in progress. On return to mode 2 the engine is idle and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 off, 1 bit-bang, 2 sequenced, 3 off |
| clkdiv_i | input | DIV_W | Prescaler value; one tick every clkdiv_i+1 clocks |
| steps_i | input | 4*STEP_W | Phase step counts; phase n in bits [STEP_W*n +: STEP_W] |
| bb_lines_i | input | 2 | Bit-bang levels: bit 1 SCL, bit 0 SDA (1 = released) |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine can accept a command |
| cmd_op_i | input | 3 | 1 start, 2 stop, 3 write, 4 read, 5 repeated start; other codes are dropped |
| cmd_data_i | input | 8 | Byte to write |
| cmd_nack_i | input | 1 | For reads: 1 answers the byte with NACK |
| done_o | output | 1 | One-cycle pulse at command end |
| rsp_data_o | output | 8 | Byte sampled during the last write or read |
| rsp_nack_o | output | 1 | Ninth-bit level of the last byte (1 = NACK) |
| busy_o | output | 1 | A command is executing |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| bb_sda_o | output | 1 | SDA level captured each clock in bit-bang mode |

## Verification
Several properties are checked on every cycle:
- The phase counter advances only at a phase end, and always by one.
- The driven SDA level never changes while SCL stays released inside a data or acknowledge slot.
- The done pulse lasts one cycle.
- Bit-bang drive and sampling follow the register bits and the line with a one-clock delay.
- Off modes release the lines.

Only the bench scenarios can show the end-to-end behaviour. A bus monitor recovers start and stop conditions, MSB-first bytes and ninth-bit levels, and a receiver model answers. These scenarios establish measured SCL high times and rise-to-rise periods under two different step and divider settings, and the shape of repeated start against stop. They also show that an abort mid-byte leaves an engine that works when re-enabled.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PH_W       = $clog2(NUM_PHASES);

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_BANG = 2'd1,
    MODE_SEQ  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_RESTART = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    SL_START,
    SL_RESTART,
    SL_STOP,
    SL_DATA,
    SL_ACK
  } slot_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } lines_t;
endpackage

// File: rtl/i2cp_prescaler.sv
module i2cp_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cp_phase_timer.sv
module i2cp_phase_timer
  import i2cp_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int STEP_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic [DIV_W-1:0]             div,
  input  logic [NUM_PHASES*STEP_W-1:0] steps,
  output logic [PH_W-1:0]              phase,
  output logic                         phase_end,
  output logic                         slot_end
);
  logic              tick;
  logic [STEP_W-1:0] step_arr [NUM_PHASES];
  logic [STEP_W-1:0] step_cnt_q;
  logic [PH_W-1:0]   phase_q;
  logic [STEP_W-1:0] cur_step;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_unpack
    assign step_arr[g] = steps[g*STEP_W +: STEP_W];
  end

  i2cp_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .div (div),
    .tick(tick)
  );

  assign cur_step  = step_arr[phase_q];
  assign phase_end = tick && (step_cnt_q == cur_step);
  assign slot_end  = phase_end && (phase_q == PH_W'(NUM_PHASES-1));
  assign phase     = phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      step_cnt_q <= '0;
      phase_q    <= '0;
    end else if (tick) begin
      if (step_cnt_q == cur_step) begin
        step_cnt_q <= '0;
        phase_q    <= phase_q + 1'b1;
      end else begin
        step_cnt_q <= step_cnt_q + 1'b1;
      end
    end
  end

  assert_phase_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (run && phase_end) |=> (phase_q == $past(phase_q) + 1'b1));

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !phase_end) |=> $stable(phase_q));
endmodule

// File: rtl/i2cp_bit_fsm.sv
module i2cp_bit_fsm
  import i2cp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [7:0]      cmd_data,
  input  logic            cmd_nack,
  output logic            cmd_ready,
  input  logic [PH_W-1:0] phase,
  input  logic            phase_end,
  input  logic            slot_end,
  output logic            run,
  input  logic            sda_in,
  output lines_t          lines,
  output logic            done,
  output logic [7:0]      rsp_data,
  output logic            rsp_nack
);
  logic       busy_q, done_q, is_read_q, nack_req_q, samp_q, data_q;
  slot_e      slot_q;
  logic [7:0] shreg_q, rsp_data_q;
  logic [2:0] bitcnt_q;
  logic       rsp_nack_q;
  lines_t     lines_q, lines_n;
  logic       accept;

  assign cmd_ready = !busy_q;
  assign run       = busy_q;
  assign accept    = cmd_valid && !busy_q;
  assign lines     = lines_q;
  assign done      = done_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_nack  = rsp_nack_q;

  always_comb begin
    lines_n = lines_q;
    unique case (slot_q)
      SL_START: begin
        lines_n.scl_low = (phase == 2'd3);
        lines_n.sda_low = (phase >= 2'd2);
      end
      SL_RESTART: begin
        lines_n.scl_low = (phase == 2'd0) || (phase == 2'd3);
        lines_n.sda_low = (phase >= 2'd2);
      end
      SL_STOP: begin
        lines_n.scl_low = (phase == 2'd0);
        lines_n.sda_low = (phase <= 2'd1);
      end
      SL_DATA: begin
        lines_n.scl_low = (phase == 2'd0) || (phase == 2'd3);
        lines_n.sda_low = !is_read_q && !shreg_q[7];
      end
      SL_ACK: begin
        lines_n.scl_low = (phase == 2'd0) || (phase == 2'd3);
        lines_n.sda_low = is_read_q && !nack_req_q;
      end
      default: lines_n = lines_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      slot_q     <= SL_START;
      is_read_q  <= 1'b0;
      nack_req_q <= 1'b0;
      shreg_q    <= '0;
      bitcnt_q   <= '0;
      samp_q     <= 1'b1;
      rsp_data_q <= '0;
      rsp_nack_q <= 1'b0;
      lines_q    <= '0;
      data_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      data_q <= busy_q && ((slot_q == SL_DATA) || (slot_q == SL_ACK));
      if (busy_q) lines_q <= lines_n;

      if (accept) begin
        unique case (op_e'(cmd_op))
          OP_START:   begin busy_q <= 1'b1; slot_q <= SL_START;   end
          OP_RESTART: begin busy_q <= 1'b1; slot_q <= SL_RESTART; end
          OP_STOP:    begin busy_q <= 1'b1; slot_q <= SL_STOP;    end
          OP_WRITE, OP_READ: begin
            busy_q     <= 1'b1;
            slot_q     <= SL_DATA;
            is_read_q  <= (op_e'(cmd_op) == OP_READ);
            nack_req_q <= cmd_nack;
            shreg_q    <= cmd_data;
            bitcnt_q   <= '0;
          end
          default: ;
        endcase
      end

      if (busy_q && phase_end && (phase == 2'd2)) samp_q <= sda_in;

      if (busy_q && slot_end) begin
        unique case (slot_q)
          SL_DATA: begin
            shreg_q  <= {shreg_q[6:0], samp_q};
            bitcnt_q <= bitcnt_q + 1'b1;
            if (bitcnt_q == 3'd7) slot_q <= SL_ACK;
          end
          SL_ACK: begin
            busy_q     <= 1'b0;
            done_q     <= 1'b1;
            rsp_data_q <= shreg_q;
            rsp_nack_q <= samp_q;
          end
          default: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  // R6: SDA may only move while SCL is held low inside data and acknowledge slots
  assert_sda_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (data_q && $past(data_q) && !lines_q.scl_low && !$past(lines_q.scl_low))
      |-> (lines_q.sda_low == $past(lines_q.sda_low)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/i2c_phase_engine.sv
module i2c_phase_engine
  import i2cp_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int STEP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_i,
  input  logic [DIV_W-1:0]        clkdiv_i,
  input  logic [4*STEP_W-1:0]     steps_i,
  input  logic [1:0]              bb_lines_i,
  input  logic                    cmd_valid_i,
  output logic                    cmd_ready_o,
  input  logic [2:0]              cmd_op_i,
  input  logic [7:0]              cmd_data_i,
  input  logic                    cmd_nack_i,
  output logic                    done_o,
  output logic [7:0]              rsp_data_o,
  output logic                    rsp_nack_o,
  output logic                    busy_o,
  input  logic                    sda_i,
  output logic                    scl_oe_o,
  output logic                    sda_oe_o,
  output logic                    bb_sda_o
);
  localparam int STEPS_W = NUM_PHASES * STEP_W;

  mode_e           mode;
  logic            seq_on, eng_rst;
  logic            run, phase_end, slot_end, fsm_ready;
  logic [PH_W-1:0] phase;
  lines_t          lines;
  logic            scl_oe_q, sda_oe_q, bb_sda_q;

  assign mode    = mode_e'(mode_i);
  assign seq_on  = (mode == MODE_SEQ);
  assign eng_rst = rst || !seq_on;

  i2cp_phase_timer #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_timer (
    .clk      (clk),
    .rst      (eng_rst),
    .run      (run),
    .div      (clkdiv_i),
    .steps    (steps_i[STEPS_W-1:0]),
    .phase    (phase),
    .phase_end(phase_end),
    .slot_end (slot_end)
  );

  i2cp_bit_fsm u_fsm (
    .clk      (clk),
    .rst      (eng_rst),
    .cmd_valid(cmd_valid_i && seq_on),
    .cmd_op   (cmd_op_i),
    .cmd_data (cmd_data_i),
    .cmd_nack (cmd_nack_i),
    .cmd_ready(fsm_ready),
    .phase    (phase),
    .phase_end(phase_end),
    .slot_end (slot_end),
    .run      (run),
    .sda_in   (sda_i),
    .lines    (lines),
    .done     (done_o),
    .rsp_data (rsp_data_o),
    .rsp_nack (rsp_nack_o)
  );

  assign cmd_ready_o = fsm_ready && seq_on;
  assign busy_o      = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      bb_sda_q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_BANG: begin
          scl_oe_q <= !bb_lines_i[1];
          sda_oe_q <= !bb_lines_i[0];
          bb_sda_q <= sda_i;
        end
        MODE_SEQ: begin
          scl_oe_q <= lines.scl_low;
          sda_oe_q <= lines.sda_low;
        end
        default: begin
          scl_oe_q <= 1'b0;
          sda_oe_q <= 1'b0;
        end
      endcase
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
  assign bb_sda_o = bb_sda_q;

  assert_bang_lines_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> ((scl_oe_o == !$past(bb_lines_i[1])) &&
                          (sda_oe_o == !$past(bb_lines_i[0]))));

  assert_bang_sample_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> (bb_sda_o == $past(sda_i)));

  assert_off_release_R11: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == 2'd0) || (mode_i == 2'd3)) |=> (!scl_oe_o && !sda_oe_o && !busy_o));
endmodule

// File: tb/i2c_phase_engine_test.sv
module i2c_phase_engine_test;
  import i2cp_pkg::*;

  localparam int DIV_W  = 8;
  localparam int STEP_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst = 1'b1;
  logic [1:0]         mode = 2'd2;
  logic [DIV_W-1:0]   clkdiv = '0;
  logic [4*STEP_W-1:0] steps = '0;
  logic [1:0]         bb_lines = 2'b11;
  logic               cmd_valid = 1'b0;
  logic               cmd_ready_o;
  logic [2:0]         cmd_op = 3'd0;
  logic [7:0]         cmd_data = 8'd0;
  logic               cmd_nack = 1'b0;
  logic               done_o, rsp_nack_o, busy_o, sda_i;
  logic [7:0]         rsp_data_o;
  logic               scl_oe_o, sda_oe_o, bb_sda_o;

  i2c_phase_engine #(.DIV_W(DIV_W), .STEP_W(STEP_W)) uut (
    .clk(clk), .rst(rst), .mode_i(mode), .clkdiv_i(clkdiv), .steps_i(steps),
    .bb_lines_i(bb_lines), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready_o),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .cmd_nack_i(cmd_nack),
    .done_o(done_o), .rsp_data_o(rsp_data_o), .rsp_nack_o(rsp_nack_o),
    .busy_o(busy_o), .sda_i(sda_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .bb_sda_o(bb_sda_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // receiver model and bus monitor
  bit         mon_en = 1'b0;
  bit         slv_read = 1'b0, slv_ack = 1'b0, ext_pull = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  logic       slv_pull;
  logic       scl_line, sda_line;
  int         idx = -1;

  always_comb begin
    slv_pull = 1'b0;
    if (mon_en && idx >= 0 && idx <= 7 && slv_read) slv_pull = !slv_byte[3'(7 - idx)];
    if (mon_en && idx == 8 && !slv_read)            slv_pull = slv_ack;
  end

  assign scl_line = !scl_oe_o;
  assign sda_line = !(sda_oe_o || slv_pull || ext_pull);
  assign sda_i    = sda_line;

  logic [8:0] exp_q[$];
  logic [8:0] bits = '0;
  logic [8:0] exp_item;
  int start_cnt = 0, stop_cnt = 0;
  int hi_cnt = 0, last_high = 0, last_period = 0, cyc = 0, last_rise = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (scl_line && prev_scl && prev_sda && !sda_line) begin
        start_cnt++; idx = -1;
      end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
        stop_cnt++; idx = -1;
      end
      if (scl_line && !prev_scl) begin
        hi_cnt = 1;
        last_period = cyc - last_rise;
        last_rise = cyc;
        if (idx >= 0 && idx <= 8) begin
          bits = {bits[7:0], sda_line};
          if (idx == 8) begin
            if (exp_q.size() == 0) begin
              chk_eq("R6/R7", "unexpected byte on bus", int'(bits), 0);
            end else begin
              exp_item = exp_q.pop_front();
              chk_eq("R6/R7", "bus byte and ninth bit", int'(bits), int'(exp_item));
            end
          end
        end
      end else if (scl_line) begin
        hi_cnt++;
      end
      if (!scl_line && prev_scl) begin
        last_high = hi_cnt;
        idx = (idx >= 8) ? 0 : idx + 1;
        if (idx == 0) bits = '0;
      end
    end else begin
      idx = -1;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // driver
  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic nk);
    int n;
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_nack = nk; cmd_valid = 1'b1;
    while (!cmd_ready_o) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_eq("R8", "busy after accept", int'(busy_o), 1);
    chk_eq("R8", "ready low while busy", int'(cmd_ready_o), 0);
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk_eq("R8", "done seen", int'(done_o), 1);
    @(negedge clk);
    chk_eq("R8", "done single cycle and ready", int'({done_o, cmd_ready_o}), 1);
  endtask

  task automatic do_write(input logic [7:0] d, input bit ack);
    slv_read = 1'b0; slv_ack = ack;
    exp_q.push_back({d, !ack});
    issue(3'(OP_WRITE), d, 1'b0);
    chk_eq("R6", "write ninth-bit result", int'(rsp_nack_o), int'(!ack));
    chk_eq("R6", "write readback", int'(rsp_data_o), int'(d));
  endtask

  task automatic do_read(input logic [7:0] d, input bit nk);
    slv_read = 1'b1; slv_byte = d;
    exp_q.push_back({d, nk});
    issue(3'(OP_READ), 8'h00, nk);
    chk_eq("R7", "read data", int'(rsp_data_o), int'(d));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // config A: div 1, steps P0=3 P1=2 P2=2 P3=4
    clkdiv = 8'd1;
    steps  = {8'd4, 8'd2, 8'd2, 8'd3};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1", "enables after reset", int'({scl_oe_o, sda_oe_o}), 0);
    chk_eq("R1", "busy/done after reset", int'({busy_o, done_o}), 0);
    chk_eq("R1", "ready after reset", int'(cmd_ready_o), 1);
    mon_en = 1'b1;
    @(negedge clk);

    issue(3'(OP_START), 8'h00, 1'b0);
    chk_eq("R3", "start seen", start_cnt, 1);
    chk_eq("R3", "both pulled after start", int'({scl_oe_o, sda_oe_o}), 3);

    do_write(8'hA5, 1'b1);
    chk_eq("R2", "SCL high time config A", last_high, 12);
    chk_eq("R2", "SCL period config A", last_period, 30);
    do_write(8'h5A, 1'b0);

    issue(3'(OP_RESTART), 8'h00, 1'b0);
    chk_eq("R4", "repeated start seen", start_cnt, 2);
    chk_eq("R4", "no stop on repeated start", stop_cnt, 0);
    chk_eq("R4", "both pulled after repeated start", int'({scl_oe_o, sda_oe_o}), 3);

    do_read(8'h3C, 1'b0);
    do_read(8'hC3, 1'b1);

    issue(3'(OP_STOP), 8'h00, 1'b0);
    chk_eq("R5", "stop seen", stop_cnt, 1);
    chk_eq("R5", "released after stop", int'({scl_oe_o, sda_oe_o}), 0);

    // config B: div 0, steps P0=1 P1=4 P2=3 P3=2
    clkdiv = 8'd0;
    steps  = {8'd2, 8'd3, 8'd4, 8'd1};
    issue(3'(OP_START), 8'h00, 1'b0);
    do_write(8'h81, 1'b1);
    chk_eq("R2", "SCL high time config B", last_high, 9);
    chk_eq("R2", "SCL period config B", last_period, 14);
    issue(3'(OP_STOP), 8'h00, 1'b0);
    chk_eq("R5", "second stop seen", stop_cnt, 2);

    // abort mid-byte
    issue(3'(OP_START), 8'h00, 1'b0);
    slv_read = 1'b0; slv_ack = 1'b1;
    @(negedge clk);
    cmd_op = 3'(OP_WRITE); cmd_data = 8'hF0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (40) @(negedge clk);
    mon_en = 1'b0;
    mode = 2'd0;
    repeat (2) @(negedge clk);
    chk_eq("R11", "off mode releases lines", int'({scl_oe_o, sda_oe_o}), 0);
    chk_eq("R11", "off mode busy/ready", int'({busy_o, cmd_ready_o}), 0);
    mode = 2'd2;
    @(negedge clk);
    chk_eq("R11", "idle and ready after re-enable", int'({busy_o, cmd_ready_o}), 1);
    mon_en = 1'b1;
    @(negedge clk);
    issue(3'(OP_START), 8'h00, 1'b0);
    do_write(8'h3E, 1'b1);
    issue(3'(OP_STOP), 8'h00, 1'b0);

    // bit-bang
    mon_en = 1'b0;
    mode = 2'd1;
    bb_lines = 2'b01;
    repeat (2) @(negedge clk);
    chk_eq("R9", "bit-bang SCL low SDA released", int'({scl_oe_o, sda_oe_o}), 2);
    bb_lines = 2'b10;
    repeat (2) @(negedge clk);
    chk_eq("R9", "bit-bang SCL released SDA low", int'({scl_oe_o, sda_oe_o}), 1);
    bb_lines = 2'b11;
    ext_pull = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R10", "bit-bang sample low", int'(bb_sda_o), 0);
    ext_pull = 1'b0;
    repeat (2) @(negedge clk);
    chk_eq("R10", "bit-bang sample high", int'(bb_sda_o), 1);
    bb_lines = 2'b00;
    repeat (2) @(negedge clk);
    chk_eq("R9", "bit-bang both low", int'({scl_oe_o, sda_oe_o}), 3);
    mode = 2'd3;
    repeat (2) @(negedge clk);
    chk_eq("R11", "reserved mode releases lines", int'({scl_oe_o, sda_oe_o}), 0);

    chk_eq("R6", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule